// File: doc/BRIEF.md
# Multi-Core Interrupt Routing Controller

This block sits between the interrupt sources of a small multiprocessor cluster and the cores. For every core it keeps three classes of pending request: peripheral, mailbox and timer. It presents them on that core's three hardware interrupt lines. Each class is gated by a per-core, per-class enable bit. A per-core global enable sits above them and can silence all three classes at once. A separate debug request path per core has its own enable and is not affected by the global enable.

Software reaches the block through one or more simple 32-bit register ports. A write has one cycle of latency, and a read returns data combinationally. Each core owns a 32-bit mailbox word. Writing a nonzero message raises that core's mailbox interrupt, and writing zero withdraws it, so the mailbox doubles as an inter-core signalling path. A single hardware spinlock gives cores atomic ownership of shared state. A write to the acquire register only takes effect while the lock is free, and in that case it stores the writer's value and marks the lock as held in one step.

Top module: `irq_router`

## Requirements
- R1: After reset all interrupt outputs are 0, and every enable register, every mailbox and the lock word read as 0.
- R2: Core c's interrupt lines sit at core_hw_irq[3c+k], where k=0 is peripheral, k=1 is mailbox and k=2 is timer.
- R3: While global enable bit c (offset 0x020) is 0, core_hw_irq[3c+2:3c] is 0 whatever is pending.
- R4: While global enable bit c is 1, line k of core c equals pending AND the class enable bit c, read from offset 0x010 (peripheral), 0x014 (mailbox) or 0x018 (timer).
- R5: Core c's mailbox sits at offset 0x1000+4c and reads back the last 32-bit value written to it.
- R6: A nonzero mailbox write sets core c's mailbox pending bit (readable at 0x004), and a zero write clears it.
- R7: Peripheral and timer pending bits (readable at 0x000 and 0x008) copy peri_irq_in and timer_irq_in at each clock edge. Bus writes to these offsets have no effect.
- R8: A write to the acquire register (0x034) while the lock is free sets the lock bit (bit 31) and stores wdata[30:0] as the lock value. Offsets 0x030 and 0x034 both read {lock, value}.
- R9: A write to the acquire register while the lock is held leaves both lock and value unchanged.
- R10: A write to 0x030 with bit 31 clear releases the lock and keeps the value. A write with bit 31 set has no effect. A release in the same cycle as an acquire takes precedence.
- R11: When several ports write the acquire register in one cycle while the lock is free, the lowest-numbered port wins. The same order settles same-cycle writes to any other register.
- R12: core_dbg_irq[c] equals the sampled dbg_req_in[c] AND the debug enable bit c (offset 0x01C), independent of the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | NUM_PORTS | Write strobe per bus port |
| bus_addr | input | NUM_PORTS*ADDR_W | Byte address per port, port 0 in the low bits |
| bus_wdata | input | NUM_PORTS*DATA_W | Write data per port |
| bus_rdata | output | NUM_PORTS*DATA_W | Combinational read data per port |
| peri_irq_in | input | NUM_CORES | Peripheral request level per core |
| timer_irq_in | input | NUM_CORES | Timer request level per core |
| dbg_req_in | input | NUM_CORES | Debug request from the debug port per core |
| core_hw_irq | output | 3*NUM_CORES | Three hardware interrupt lines per core |
| core_dbg_irq | output | NUM_CORES | Debug interrupt per core |

## Verification
The routing path is driven with a pattern in which each core has a different class active: peripheral on core 1, timer on core 2 and mailbox on core 3. A swapped line index or a wrong core index therefore shows up as a distinct wrong bit. Clearing one class enable at a time, then one global bit, tells the local gate apart from the global gate. The debug path is checked while global enables are off to confirm its independence. The spinlock is tried with acquire-when-free, acquire-when-held, a set-bit release that must be ignored, a real release, and two ports racing, which separates the lock condition from the port priority.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

   localparam int CLASS_CNT = 3;

   typedef enum logic [1:0] {
      CLS_PERI  = 2'd0,
      CLS_MBOX  = 2'd1,
      CLS_TIMER = 2'd2
   } irq_class_e;

   localparam int OFS_PERI_PEND = 32'h0000;
   localparam int OFS_MBOX_PEND = 32'h0004;
   localparam int OFS_TMR_PEND  = 32'h0008;
   localparam int OFS_DBG_PEND  = 32'h000C;
   localparam int OFS_PERI_EN   = 32'h0010;
   localparam int OFS_MBOX_EN   = 32'h0014;
   localparam int OFS_TMR_EN    = 32'h0018;
   localparam int OFS_DBG_EN    = 32'h001C;
   localparam int OFS_GLOB_EN   = 32'h0020;
   localparam int OFS_LOCK      = 32'h0030;
   localparam int OFS_ACQUIRE   = 32'h0034;
   localparam int OFS_MBOX_BASE = 32'h1000;
   localparam int MBOX_STRIDE   = 4;

   function automatic int mbox_ofs(input int core);
      return OFS_MBOX_BASE + MBOX_STRIDE * core;
   endfunction

endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
   import irq_router_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int NUM_PORTS = 2,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_PORTS-1:0]        wr_en,
   input  logic [NUM_PORTS*ADDR_W-1:0] addr_f,
   input  logic [NUM_PORTS*DATA_W-1:0] wdata_f,
   input  logic [NUM_CORES-1:0]        peri_in,
   input  logic [NUM_CORES-1:0]        timer_in,
   input  logic [NUM_CORES-1:0]        dbg_in,
   input  logic [DATA_W-1:0]           lock_word,
   output logic [NUM_PORTS*DATA_W-1:0] rdata_f,
   output logic [NUM_CORES-1:0]        peri_pend,
   output logic [NUM_CORES-1:0]        mbox_pend,
   output logic [NUM_CORES-1:0]        timer_pend,
   output logic [NUM_CORES-1:0]        dbg_pend,
   output logic [NUM_CORES-1:0]        peri_en,
   output logic [NUM_CORES-1:0]        mbox_en,
   output logic [NUM_CORES-1:0]        timer_en,
   output logic [NUM_CORES-1:0]        dbg_en,
   output logic [NUM_CORES-1:0]        glob_en
);

   logic [DATA_W-1:0]    mbox_q [NUM_CORES];
   logic [DATA_W-1:0]    mbox_d [NUM_CORES];
   logic [NUM_CORES-1:0] peri_en_d, mbox_en_d, timer_en_d, dbg_en_d, glob_en_d;

   // Ports are applied highest first so the lowest-numbered port lands last (R11).
   always_comb begin
      peri_en_d  = peri_en;
      mbox_en_d  = mbox_en;
      timer_en_d = timer_en;
      dbg_en_d   = dbg_en;
      glob_en_d  = glob_en;
      for (int c = 0; c < NUM_CORES; c++) mbox_d[c] = mbox_q[c];
      for (int p = NUM_PORTS - 1; p >= 0; p--) begin
         if (wr_en[p]) begin
            if (addr_f[p*ADDR_W +: ADDR_W] == ADDR_W'(OFS_PERI_EN))
               peri_en_d = wdata_f[p*DATA_W +: NUM_CORES];
            else if (addr_f[p*ADDR_W +: ADDR_W] == ADDR_W'(OFS_MBOX_EN))
               mbox_en_d = wdata_f[p*DATA_W +: NUM_CORES];
            else if (addr_f[p*ADDR_W +: ADDR_W] == ADDR_W'(OFS_TMR_EN))
               timer_en_d = wdata_f[p*DATA_W +: NUM_CORES];
            else if (addr_f[p*ADDR_W +: ADDR_W] == ADDR_W'(OFS_DBG_EN))
               dbg_en_d = wdata_f[p*DATA_W +: NUM_CORES];
            else if (addr_f[p*ADDR_W +: ADDR_W] == ADDR_W'(OFS_GLOB_EN))
               glob_en_d = wdata_f[p*DATA_W +: NUM_CORES];
            for (int c = 0; c < NUM_CORES; c++) begin
               if (addr_f[p*ADDR_W +: ADDR_W] == ADDR_W'(mbox_ofs(c)))
                  mbox_d[c] = wdata_f[p*DATA_W +: DATA_W];
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         peri_en    <= '0;
         mbox_en    <= '0;
         timer_en   <= '0;
         dbg_en     <= '0;
         glob_en    <= '0;
         peri_pend  <= '0;
         timer_pend <= '0;
         dbg_pend   <= '0;
         for (int c = 0; c < NUM_CORES; c++) mbox_q[c] <= '0;
      end else begin
         peri_en    <= peri_en_d;
         mbox_en    <= mbox_en_d;
         timer_en   <= timer_en_d;
         dbg_en     <= dbg_en_d;
         glob_en    <= glob_en_d;
         peri_pend  <= peri_in;
         timer_pend <= timer_in;
         dbg_pend   <= dbg_in;
         for (int c = 0; c < NUM_CORES; c++) mbox_q[c] <= mbox_d[c];
      end
   end

   // Mailbox pending is defined by the stored message being nonzero (R6).
   for (genvar c = 0; c < NUM_CORES; c++) begin : g_mbox_pend
      assign mbox_pend[c] = |mbox_q[c];
   end

   always_comb begin
      rdata_f = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (addr_f[p*ADDR_W +: ADDR_W] == ADDR_W'(OFS_PERI_PEND))
            rdata_f[p*DATA_W +: DATA_W] = DATA_W'(peri_pend);
         else if (addr_f[p*ADDR_W +: ADDR_W] == ADDR_W'(OFS_MBOX_PEND))
            rdata_f[p*DATA_W +: DATA_W] = DATA_W'(mbox_pend);
         else if (addr_f[p*ADDR_W +: ADDR_W] == ADDR_W'(OFS_TMR_PEND))
            rdata_f[p*DATA_W +: DATA_W] = DATA_W'(timer_pend);
         else if (addr_f[p*ADDR_W +: ADDR_W] == ADDR_W'(OFS_DBG_PEND))
            rdata_f[p*DATA_W +: DATA_W] = DATA_W'(dbg_pend);
         else if (addr_f[p*ADDR_W +: ADDR_W] == ADDR_W'(OFS_PERI_EN))
            rdata_f[p*DATA_W +: DATA_W] = DATA_W'(peri_en);
         else if (addr_f[p*ADDR_W +: ADDR_W] == ADDR_W'(OFS_MBOX_EN))
            rdata_f[p*DATA_W +: DATA_W] = DATA_W'(mbox_en);
         else if (addr_f[p*ADDR_W +: ADDR_W] == ADDR_W'(OFS_TMR_EN))
            rdata_f[p*DATA_W +: DATA_W] = DATA_W'(timer_en);
         else if (addr_f[p*ADDR_W +: ADDR_W] == ADDR_W'(OFS_DBG_EN))
            rdata_f[p*DATA_W +: DATA_W] = DATA_W'(dbg_en);
         else if (addr_f[p*ADDR_W +: ADDR_W] == ADDR_W'(OFS_GLOB_EN))
            rdata_f[p*DATA_W +: DATA_W] = DATA_W'(glob_en);
         else if (addr_f[p*ADDR_W +: ADDR_W] == ADDR_W'(OFS_LOCK) ||
                  addr_f[p*ADDR_W +: ADDR_W] == ADDR_W'(OFS_ACQUIRE))
            rdata_f[p*DATA_W +: DATA_W] = lock_word;
         for (int c = 0; c < NUM_CORES; c++) begin
            if (addr_f[p*ADDR_W +: ADDR_W] == ADDR_W'(mbox_ofs(c)))
               rdata_f[p*DATA_W +: DATA_W] = mbox_q[c];
         end
      end
   end

endmodule

// File: rtl/irq_router_lock.sv
module irq_router_lock
   import irq_router_pkg::*;
#(
   parameter int NUM_PORTS = 2,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_PORTS-1:0]        wr_en,
   input  logic [NUM_PORTS*ADDR_W-1:0] addr_f,
   input  logic [NUM_PORTS*DATA_W-1:0] wdata_f,
   output logic [DATA_W-1:0]           lock_word,
   output logic                        acq_any,
   output logic                        rel_any
);

   localparam int LOCK_BIT = DATA_W - 1;
   localparam int VAL_W    = DATA_W - 1;

   logic             held_q;
   logic [VAL_W-1:0] val_q;
   logic [VAL_W-1:0] win_val;

   // Lowest-numbered acquiring port is assigned last and therefore wins (R11).
   always_comb begin
      acq_any = 1'b0;
      rel_any = 1'b0;
      win_val = '0;
      for (int p = NUM_PORTS - 1; p >= 0; p--) begin
         if (wr_en[p] && addr_f[p*ADDR_W +: ADDR_W] == ADDR_W'(OFS_ACQUIRE)) begin
            acq_any = 1'b1;
            win_val = wdata_f[p*DATA_W +: VAL_W];
         end
         if (wr_en[p] && addr_f[p*ADDR_W +: ADDR_W] == ADDR_W'(OFS_LOCK) &&
             !wdata_f[p*DATA_W + LOCK_BIT])
            rel_any = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         val_q  <= '0;
      end else if (rel_any) begin
         held_q <= 1'b0;
      end else if (!held_q && acq_any) begin
         held_q <= 1'b1;
         val_q  <= win_val;
      end
   end

   assign lock_word = {held_q, val_q};

endmodule

// File: rtl/irq_router_gate.sv
module irq_router_gate
   import irq_router_pkg::*;
(
   input  logic [CLASS_CNT-1:0] pend,
   input  logic [CLASS_CNT-1:0] cls_en,
   input  logic                 glob_en,
   input  logic                 dbg_pend,
   input  logic                 dbg_en,
   output logic [CLASS_CNT-1:0] hw_irq,
   output logic                 dbg_irq
);

   for (genvar k = 0; k < CLASS_CNT; k++) begin : g_cls
      assign hw_irq[k] = glob_en & cls_en[k] & pend[k];
   end

   assign dbg_irq = dbg_en & dbg_pend;

endmodule

// File: rtl/irq_router.sv
module irq_router
   import irq_router_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int NUM_PORTS = 2,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_PORTS-1:0]           bus_wr_en,
   input  logic [NUM_PORTS*ADDR_W-1:0]    bus_addr,
   input  logic [NUM_PORTS*DATA_W-1:0]    bus_wdata,
   output logic [NUM_PORTS*DATA_W-1:0]    bus_rdata,
   input  logic [NUM_CORES-1:0]           peri_irq_in,
   input  logic [NUM_CORES-1:0]           timer_irq_in,
   input  logic [NUM_CORES-1:0]           dbg_req_in,
   output logic [CLASS_CNT*NUM_CORES-1:0] core_hw_irq,
   output logic [NUM_CORES-1:0]           core_dbg_irq
);

   localparam int MBOX_TOP = OFS_MBOX_BASE + MBOX_STRIDE * NUM_CORES;

   if (NUM_CORES < 1 || NUM_CORES > DATA_W - 1) begin : g_bad_cores
      $error("irq_router: NUM_CORES must fit inside one data word");
   end
   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("irq_router: at least one bus port is required");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("irq_router: DATA_W too narrow for the lock word");
   end
   if (MBOX_TOP > (1 << ADDR_W)) begin : g_bad_addr
      $error("irq_router: ADDR_W cannot reach the mailbox window");
   end

   logic [NUM_CORES-1:0] peri_pend, mbox_pend, timer_pend, dbg_pend;
   logic [NUM_CORES-1:0] peri_en, mbox_en, timer_en, dbg_en, glob_en;
   logic [DATA_W-1:0]    lock_word;
   logic                 acq_any, rel_any;

   irq_router_regs #(
      .NUM_CORES(NUM_CORES), .NUM_PORTS(NUM_PORTS),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_wr_en), .addr_f(bus_addr), .wdata_f(bus_wdata),
      .peri_in(peri_irq_in), .timer_in(timer_irq_in), .dbg_in(dbg_req_in),
      .lock_word(lock_word), .rdata_f(bus_rdata),
      .peri_pend(peri_pend), .mbox_pend(mbox_pend),
      .timer_pend(timer_pend), .dbg_pend(dbg_pend),
      .peri_en(peri_en), .mbox_en(mbox_en), .timer_en(timer_en),
      .dbg_en(dbg_en), .glob_en(glob_en)
   );

   irq_router_lock #(
      .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_lock (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_wr_en), .addr_f(bus_addr), .wdata_f(bus_wdata),
      .lock_word(lock_word), .acq_any(acq_any), .rel_any(rel_any)
   );

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      logic [CLASS_CNT-1:0] pend_c, en_c;
      assign pend_c[int'(CLS_PERI)]  = peri_pend[c];
      assign pend_c[int'(CLS_MBOX)]  = mbox_pend[c];
      assign pend_c[int'(CLS_TIMER)] = timer_pend[c];
      assign en_c[int'(CLS_PERI)]    = peri_en[c];
      assign en_c[int'(CLS_MBOX)]    = mbox_en[c];
      assign en_c[int'(CLS_TIMER)]   = timer_en[c];

      irq_router_gate u_gate (
         .pend(pend_c), .cls_en(en_c), .glob_en(glob_en[c]),
         .dbg_pend(dbg_pend[c]), .dbg_en(dbg_en[c]),
         .hw_irq(core_hw_irq[c*CLASS_CNT +: CLASS_CNT]),
         .dbg_irq(core_dbg_irq[c])
      );
   end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
   parameter int NUM_CORES = 4,
   parameter int VAL_W     = 31
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [3*NUM_CORES-1:0] core_hw_irq,
   input logic [NUM_CORES-1:0]   core_dbg_irq,
   input logic [NUM_CORES-1:0]   peri_irq_in,
   input logic [NUM_CORES-1:0]   timer_irq_in,
   input logic [NUM_CORES-1:0]   glob_en,
   input logic [NUM_CORES-1:0]   dbg_en,
   input logic [NUM_CORES-1:0]   mbox_pend,
   input logic                   held,
   input logic [VAL_W-1:0]       lock_val,
   input logic                   acq_any,
   input logic                   rel_any
);

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core_chk
      p_global_block_r3 : assert property (@(posedge clk) disable iff (!rst_n)
         !glob_en[c] |-> core_hw_irq[3*c +: 3] == 3'b000);
      p_peri_sample_r7 : assert property (@(posedge clk) disable iff (!rst_n)
         core_hw_irq[3*c] |-> $past(peri_irq_in[c]));
      p_timer_sample_r7 : assert property (@(posedge clk) disable iff (!rst_n)
         core_hw_irq[3*c+2] |-> $past(timer_irq_in[c]));
      p_mbox_route_r6 : assert property (@(posedge clk) disable iff (!rst_n)
         core_hw_irq[3*c+1] |-> mbox_pend[c]);
      p_dbg_gate_r12 : assert property (@(posedge clk) disable iff (!rst_n)
         core_dbg_irq[c] |-> dbg_en[c]);
   end

   p_acquire_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (!held && acq_any && !rel_any) |=> held);
   p_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (held && !rel_any) |=> (held && $stable(lock_val)));
   p_release_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      rel_any |=> (!held && $stable(lock_val)));

endmodule

bind irq_router irq_router_chk #(.NUM_CORES(NUM_CORES), .VAL_W(DATA_W-1)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .core_hw_irq(core_hw_irq), .core_dbg_irq(core_dbg_irq),
   .peri_irq_in(peri_irq_in), .timer_irq_in(timer_irq_in),
   .glob_en(glob_en), .dbg_en(dbg_en), .mbox_pend(mbox_pend),
   .held(lock_word[DATA_W-1]), .lock_val(lock_word[DATA_W-2:0]),
   .acq_any(acq_any), .rel_any(rel_any)
);

// File: tb/irq_router_tb.sv
`timescale 1ns/1ps
module irq_router_tb_top;

   localparam int NC = 4;
   localparam int NP = 2;
   localparam int AW = 16;
   localparam int DW = 32;

   localparam logic [15:0] A_PERI_PEND = 16'h0000;
   localparam logic [15:0] A_MBOX_PEND = 16'h0004;
   localparam logic [15:0] A_PERI_EN   = 16'h0010;
   localparam logic [15:0] A_MBOX_EN   = 16'h0014;
   localparam logic [15:0] A_TMR_EN    = 16'h0018;
   localparam logic [15:0] A_DBG_EN    = 16'h001C;
   localparam logic [15:0] A_GLOB_EN   = 16'h0020;
   localparam logic [15:0] A_LOCK      = 16'h0030;
   localparam logic [15:0] A_ACQ       = 16'h0034;
   localparam logic [15:0] A_MBOX0     = 16'h1000;
   localparam logic [15:0] A_MBOX3     = 16'h100C;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NP-1:0]     wr_en = '0;
   logic [NP*AW-1:0]  addr_f = '0;
   logic [NP*DW-1:0]  wdata_f = '0;
   logic [NP*DW-1:0]  rdata_f;
   logic [NC-1:0]     peri_in = '0;
   logic [NC-1:0]     timer_in = '0;
   logic [NC-1:0]     dbg_in = '0;
   logic [3*NC-1:0]   hw_irq;
   logic [NC-1:0]     dbg_irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   irq_router #(.NUM_CORES(NC), .NUM_PORTS(NP), .ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .bus_wr_en(wr_en), .bus_addr(addr_f), .bus_wdata(wdata_f),
      .bus_rdata(rdata_f),
      .peri_irq_in(peri_in), .timer_irq_in(timer_in), .dbg_req_in(dbg_in),
      .core_hw_irq(hw_irq), .core_dbg_irq(dbg_irq)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr2(input logic e0, input logic [15:0] a0, input logic [31:0] d0,
                      input logic e1, input logic [15:0] a1, input logic [31:0] d1);
      @(negedge clk);
      wr_en   = {e1, e0};
      addr_f  = {a1, a0};
      wdata_f = {d1, d0};
      @(negedge clk);
      wr_en   = '0;
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      wr2(1'b1, a, d, 1'b0, 16'h0, 32'h0);
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] d);
      addr_f[15:0] = a;
      #1;
      d = rdata_f[31:0];
   endtask

   task automatic chk_hw(input string req, input logic [11:0] exp);
      check(hw_irq == exp, req, 32'(hw_irq), 32'(exp));
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk_hw("R1 outputs", 12'h000);
      check(dbg_irq == 4'h0, "R1 dbg", 32'(dbg_irq), 0);
      rd(A_GLOB_EN, d); check(d == 0, "R1 global enable", d, 0);
      rd(A_MBOX3, d);   check(d == 0, "R1 mailbox", d, 0);
      rd(A_LOCK, d);    check(d == 0, "R1 lock word", d, 0);
   endtask

   task automatic t_order;
      wr(A_GLOB_EN, 32'hF);
      wr(A_PERI_EN, 32'hF);
      wr(A_MBOX_EN, 32'hF);
      wr(A_TMR_EN, 32'hF);
      peri_in  = 4'b0010;
      timer_in = 4'b0100;
      wr(A_MBOX3, 32'h55);
      // core1 peripheral -> bit 3, core2 timer -> bit 8, core3 mailbox -> bit 10
      chk_hw("R2 line order", 12'h508);
   endtask

   task automatic t_local;
      wr(A_PERI_EN, 32'h0);
      chk_hw("R4 peripheral enable off", 12'h500);
      wr(A_TMR_EN, 32'h0);
      chk_hw("R4 timer enable off", 12'h400);
      wr(A_PERI_EN, 32'hF);
      wr(A_TMR_EN, 32'hF);
      chk_hw("R4 enables restored", 12'h508);
   endtask

   task automatic t_global;
      wr(A_GLOB_EN, 32'h0);
      chk_hw("R3 global off", 12'h000);
      wr(A_DBG_EN, 32'hF);
      dbg_in = 4'b1001;
      @(negedge clk);
      check(dbg_irq == 4'b1001, "R12 dbg with global off", 32'(dbg_irq), 32'h9);
      wr(A_DBG_EN, 32'h8);
      check(dbg_irq == 4'b1000, "R12 dbg enable", 32'(dbg_irq), 32'h8);
      wr(A_GLOB_EN, 32'hD);
      chk_hw("R3 core1 global off", 12'h500);
   endtask

   task automatic t_mbox;
      logic [31:0] d;
      wr(A_MBOX3, 32'hDEADBEEF);
      rd(A_MBOX3, d); check(d == 32'hDEADBEEF, "R5 mailbox readback", d, 32'hDEADBEEF);
      wr(A_MBOX3, 32'h0);
      chk_hw("R6 zero clears", 12'h100);
      rd(A_MBOX3, d); check(d == 0, "R5 mailbox cleared", d, 0);
      wr(A_MBOX0, 32'h7);
      chk_hw("R6 nonzero sets core0", 12'h102);
      rd(A_MBOX_PEND, d); check(d == 32'h1, "R6 pending view", d, 32'h1);
   endtask

   task automatic t_pend;
      logic [31:0] d;
      wr(A_PERI_PEND, 32'hF);
      rd(A_PERI_PEND, d); check(d == 32'h2, "R7 write ignored", d, 32'h2);
      @(negedge clk);
      peri_in = 4'b0001;
      rd(A_PERI_PEND, d); check(d == 32'h2, "R7 before edge", d, 32'h2);
      @(negedge clk);
      rd(A_PERI_PEND, d); check(d == 32'h1, "R7 after edge", d, 32'h1);
      chk_hw("R7 routed", 12'h103);
   endtask

   task automatic t_lock;
      logic [31:0] d;
      wr(A_ACQ, 32'h0000_1234);
      rd(A_LOCK, d); check(d == 32'h8000_1234, "R8 acquire", d, 32'h8000_1234);
      wr(A_ACQ, 32'h0000_5678);
      rd(A_ACQ, d); check(d == 32'h8000_1234, "R9 held", d, 32'h8000_1234);
      wr(A_LOCK, 32'h8000_0000);
      rd(A_LOCK, d); check(d == 32'h8000_1234, "R10 set-bit write ignored", d, 32'h8000_1234);
      wr(A_LOCK, 32'h0);
      rd(A_LOCK, d); check(d == 32'h0000_1234, "R10 release", d, 32'h0000_1234);
   endtask

   task automatic t_race;
      logic [31:0] d;
      wr2(1'b1, A_ACQ, 32'hAA, 1'b1, A_ACQ, 32'hBB);
      rd(A_LOCK, d); check(d == 32'h8000_00AA, "R11 lowest port wins", d, 32'h8000_00AA);
      wr(A_LOCK, 32'h0);
      wr2(1'b0, A_ACQ, 32'h0, 1'b1, A_ACQ, 32'hBB);
      rd(A_LOCK, d); check(d == 32'h8000_00BB, "R11 port1 alone", d, 32'h8000_00BB);
      wr2(1'b1, A_LOCK, 32'h0, 1'b1, A_ACQ, 32'hCC);
      rd(A_LOCK, d); check(d == 32'h0000_00BB, "R10 release beats acquire", d, 32'h0000_00BB);
      wr2(1'b1, A_GLOB_EN, 32'h1, 1'b1, A_GLOB_EN, 32'hF);
      rd(A_GLOB_EN, d); check(d == 32'h1, "R11 register write order", d, 32'h1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_order;
      t_local;
      t_global;
      t_mbox;
      t_pend;
      t_lock;
      t_race;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule